// File: doc/BRIEF.md
# Banked Three-Wire Register Bus Master

This block sits on the host side of a three-wire serial register bus. The bus has a clock line, a bidirectional data line (split here into output, output enable and input) and a read/write-select line. A client hands the block one register request at a time, either a write or a read, with an 8-bit logical address. The block turns it into bit-level bus traffic and reports completion with a one-cycle done pulse. For reads, the returned byte comes with that pulse.

The slave's register space has two banks. Logical addresses from 0x10 upward belong to the upper bank and lose their 0x10 offset on the wire. Lower addresses belong to the lower bank and are sent as they are. The master keeps a cached copy of the selected bank. It inserts a bank-select frame only when a request targets the other bank. The cache starts invalid, so the first powered access after reset always switches bank.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the cycle after the done pulse, so the client holds its request until then. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle and the client must take `rsp_rdata` in that cycle.

Top module: `tw_bank_master`

## Requirements
- R1: After reset the bus idles with `bus_clk` high, `bus_rws` low and `bus_dat_oe` low, and `busy` is low with `req_ready` high.
- R2: A logical address of 0x10 or more selects the upper bank and goes on the wire as the address minus 0x10. A lower address selects the lower bank and goes on the wire unchanged. The boundary cases are 0x10, which is sent as 0x00, and 0x0F, which is sent as 0x0F.
- R3: A bank-select frame is sent only when the target bank differs from the cached bank, and always on the first powered access after reset. The frame is 16 bits: the bank code (0x01 for the lower bank, 0x02 for the upper bank) followed by the bank-select register address 0x01.
- R4: A write is one 16-bit frame: the data byte first, then the on-wire register address byte. Each byte is shifted least-significant bit first.
- R5: Each bit holds `bus_clk` low for DLY system clocks and then high for DLY system clocks. The output data bit changes only when the clock falls, so it is stable while the clock is high. The slave captures on the rising edge.
- R6: Before the first clock fall of a frame, `bus_rws` is high and `bus_dat_oe` is enabled for at least DLY system clocks. A frame ends by releasing `bus_dat_oe` and dropping `bus_rws`. The clock runs only when `bus_rws` and `bus_dat_oe` agree.
- R7: A read sends one 8-bit frame holding only the on-wire address. Then, with `bus_rws` low and `bus_dat_oe` low, it clocks in 8 bits, least-significant first. Each bit is sampled at the end of its clock-low phase. The byte appears on `rsp_rdata` together with `rsp_valid`.
- R8: A request taken while `pwr_en` is low causes no bus activity and leaves the bank cache unchanged. It still completes with a done pulse, and a read taken in that state returns 0x00.
- R9: `busy` is high from the cycle after acceptance until the done pulse. `req_ready` is the inverse of `busy`. `rsp_valid` lasts exactly one cycle, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Interface powered; when low, requests are completed without bus traffic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master can accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Logical register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` on reads |
| busy | output | 1 | Request in progress |
| bus_clk | output | 1 | Serial clock, idles high |
| bus_rws | output | 1 | Read/write select, high during host-driven frames |
| bus_dat_o | output | 1 | Data line value when driven |
| bus_dat_oe | output | 1 | Data line driver enable |
| bus_dat_i | input | 1 | Data line value from the slave |

## Verification
The assertions assume that the client raises `req_valid` only with stable address, data and direction fields, and that `pwr_en` does not change while a request is in flight. The bench drives requests only when `req_ready` is high, holds `req_valid` for a single cycle, and changes `pwr_en` only between requests. The bench's slave model changes `bus_dat_i` only just after a clock fall, never near the sampling point at the end of the low phase. This requires DLY to be at least 2, and the bench uses 4.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BPREP,
    S_BBANK,
    S_BSEL,
    S_BEND,
    S_FPREP,
    S_FB0,
    S_FB1,
    S_FEND,
    S_RD,
    S_DONE
  } seq_t;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_LO   = 2'd1,
    BK_HI   = 2'd2
  } bank_t;

endpackage

// File: rtl/tw_bank_map.sv
module tw_bank_map #(
  parameter int unsigned AW    = 8,
  parameter int unsigned SPLIT = 16
) (
  input  logic [AW-1:0] log_addr,
  output logic          hi_bank,
  output logic [AW-1:0] wire_addr
);
  localparam logic [AW-1:0] SPLIT_V = AW'(SPLIT);

  always_comb begin
    hi_bank   = (log_addr >= SPLIT_V);
    wire_addr = hi_bank ? (log_addr - SPLIT_V) : log_addr;
  end
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine #(
  parameter int unsigned DW  = 8,
  parameter int unsigned DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rx_mode,
  input  logic [DW-1:0] tx_byte,
  input  logic          bdat_i,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          bclk,
  output logic          bdat
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DLY - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

  logic          active;
  logic          bclk_q;
  logic          rx_q;
  logic          done_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bclk_q <= 1'b1;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          bclk_q <= 1'b0;
          cnt    <= '0;
          idx    <= '0;
          rx_q   <= rx_mode;
          tx_sh  <= tx_byte;
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (!bclk_q) begin
          bclk_q <= 1'b1;
          if (rx_q) rx_sh <= {bdat_i, rx_sh[DW-1:1]};
        end else if (idx == IDX_LAST) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx    <= idx + 1'b1;
          bclk_q <= 1'b0;
          tx_sh  <= tx_sh >> 1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done    = done_q;
  assign rx_byte = rx_sh;
  assign bclk    = bclk_q;
  assign bdat    = tx_sh[0];

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q && $past(bclk_q)) |-> $stable(tx_sh[0]))
    else $error("R5 data moved while clock high");

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> !bclk_q)
    else $error("R5 clock did not fall at byte start");
endmodule

// File: rtl/tw_bank_master.sv
module tw_bank_master #(
  parameter int unsigned DLY          = 4,
  parameter int unsigned SPLIT        = 16,
  parameter int unsigned BSEL_ADDR    = 1,
  parameter int unsigned BANK_LO_CODE = 1,
  parameter int unsigned BANK_HI_CODE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       busy,
  output logic       bus_clk,
  output logic       bus_rws,
  output logic       bus_dat_o,
  output logic       bus_dat_oe,
  input  logic       bus_dat_i
);
  import tw_pkg::*;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] WAIT_LAST = CW'(DLY - 1);

  seq_t          state;
  bank_t         cache;
  bank_t         tgt_q;
  logic          op_wr, pwr_q;
  logic [DW-1:0] op_data, op_addr, rdata_q;
  logic [CW-1:0] wcnt;
  logic          go_q, rws_q, oe_q;
  logic          map_hi;
  logic [DW-1:0] map_addr;
  logic          eng_done;
  logic [DW-1:0] eng_rx;
  logic [DW-1:0] eng_tx;
  logic          wait_end;
  bank_t         req_bank;

  tw_bank_map #(.AW(DW), .SPLIT(SPLIT)) u_map (
    .log_addr (req_addr),
    .hi_bank  (map_hi),
    .wire_addr(map_addr)
  );

  always_comb begin
    unique case (state)
      S_BBANK: eng_tx = (tgt_q == BK_HI) ? DW'(BANK_HI_CODE) : DW'(BANK_LO_CODE);
      S_BSEL:  eng_tx = DW'(BSEL_ADDR);
      S_FB0:   eng_tx = op_wr ? op_data : op_addr;
      default: eng_tx = op_addr;
    endcase
  end

  tw_byte_engine #(.DW(DW), .DLY(DLY)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go_q),
    .rx_mode(state == S_RD),
    .tx_byte(eng_tx),
    .bdat_i (bus_dat_i),
    .done   (eng_done),
    .rx_byte(eng_rx),
    .bclk   (bus_clk),
    .bdat   (bus_dat_o)
  );

  assign wait_end = (wcnt == WAIT_LAST);
  assign req_bank = map_hi ? BK_HI : BK_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cache   <= BK_NONE;
      tgt_q   <= BK_NONE;
      op_wr   <= 1'b0;
      pwr_q   <= 1'b0;
      op_data <= '0;
      op_addr <= '0;
      rdata_q <= '0;
      wcnt    <= '0;
      go_q    <= 1'b0;
      rws_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      wcnt <= wait_end ? '0 : wcnt + 1'b1;
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_wr   <= req_write;
          op_data <= req_wdata;
          op_addr <= map_addr;
          tgt_q   <= req_bank;
          pwr_q   <= pwr_en;
          wcnt    <= '0;
          if (!pwr_en) begin
            if (!req_write) rdata_q <= '0;
            state <= S_DONE;
          end else begin
            rws_q <= 1'b1;
            oe_q  <= 1'b1;
            state <= (cache != req_bank) ? S_BPREP : S_FPREP;
          end
        end
        S_BPREP: if (wait_end) begin go_q <= 1'b1; state <= S_BBANK; end
        S_BBANK: if (eng_done) begin go_q <= 1'b1; state <= S_BSEL; end
        S_BSEL: if (eng_done) begin
          rws_q <= 1'b0;
          oe_q  <= 1'b0;
          wcnt  <= '0;
          cache <= tgt_q;
          state <= S_BEND;
        end
        S_BEND: if (wait_end) begin
          rws_q <= 1'b1;
          oe_q  <= 1'b1;
          state <= S_FPREP;
        end
        S_FPREP: if (wait_end) begin go_q <= 1'b1; state <= S_FB0; end
        S_FB0: if (eng_done) begin
          if (op_wr) begin
            go_q  <= 1'b1;
            state <= S_FB1;
          end else begin
            rws_q <= 1'b0;
            oe_q  <= 1'b0;
            wcnt  <= '0;
            state <= S_FEND;
          end
        end
        S_FB1: if (eng_done) begin
          rws_q <= 1'b0;
          oe_q  <= 1'b0;
          wcnt  <= '0;
          state <= S_FEND;
        end
        S_FEND: if (wait_end) begin
          if (op_wr) state <= S_DONE;
          else begin go_q <= 1'b1; state <= S_RD; end
        end
        S_RD: if (eng_done) begin rdata_q <= eng_rx; state <= S_DONE; end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign rsp_valid  = (state == S_DONE);
  assign rsp_rdata  = rdata_q;
  assign bus_rws    = rws_q;
  assign bus_dat_oe = oe_q;

  // R6
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk) |-> (bus_rws == bus_dat_oe))
    else $error("R6 clock ran outside a frame");

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy)
    else $error("R9 busy not raised after accept");

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!busy && !rsp_valid))
    else $error("R9 done not a single pulse");

  // R8
  unpowered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pwr_q) |-> (bus_clk && !bus_rws && !bus_dat_oe))
    else $error("R8 bus activity while unpowered");

  // R8
  unpowered_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !pwr_q && !op_wr) |-> (rsp_rdata == 8'h00))
    else $error("R8 unpowered read not zero");

  // R3
  bank_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FPREP) |-> (cache == tgt_q))
    else $error("R3 frame started with stale bank");
endmodule

// File: tb/test_tw_bank_master.sv
module test_tw_bank_master;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic bus_dat_i = 1'b0;
  logic req_ready, rsp_valid, busy, bus_clk, bus_rws, bus_dat_o, bus_dat_oe;
  logic [7:0] rsp_rdata;

  always #10 clk = ~clk;

  tw_bank_master #(.DLY(DLY)) i_tw_bank_master (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .bus_clk(bus_clk), .bus_rws(bus_rws), .bus_dat_o(bus_dat_o),
    .bus_dat_oe(bus_dat_oe), .bus_dat_i(bus_dat_i)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // slave model and bus monitor
  int nfr = 0;
  int fr_nb [0:63];
  logic [15:0] fr_w [0:63];
  logic [15:0] sh = '0;
  int nb = 0;
  logic [7:0] smem [0:3][0:15];
  int sbank = 0;
  logic [7:0] rd_val = '0;
  int rd_left = 0;
  logic p_clk = 1'b1, p_rws = 1'b0, p_dat = 1'b0;
  int lo_run = 0, lw_seen = 0, lw_bad = 0, dat_bad = 0, setup_bad = 0, rws_run = 0;

  initial begin
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 16; a++) smem[b][a] = 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_clk) lo_run++;
      if (bus_rws) rws_run++;
      if (bus_clk && !p_clk) begin
        lw_seen++;
        if (lo_run != DLY) lw_bad++;
        lo_run = 0;
        if (bus_rws && bus_dat_oe) begin
          sh = {bus_dat_o, sh[15:1]};
          nb++;
        end
      end
      if (bus_clk && p_clk && bus_dat_oe && (bus_dat_o != p_dat)) dat_bad++;
      if (!bus_clk && p_clk && bus_rws && nb == 0 && rws_run < DLY) setup_bad++;
      if (!bus_clk && p_clk && !bus_rws && !bus_dat_oe && rd_left > 0) begin
        bus_dat_i = rd_val[8 - rd_left];
        rd_left--;
      end
      if (!bus_rws && p_rws) begin
        if (nfr < 64) begin
          fr_nb[nfr] = nb;
          fr_w[nfr] = sh;
        end
        nfr++;
        if (nb == 16) begin
          if (sh[15:8] == 8'h01) sbank = int'(sh[1:0]);
          else smem[sbank][sh[11:8]] = sh[7:0];
        end else if (nb == 8) begin
          rd_val = smem[sbank][sh[11:8]];
          rd_left = 8;
        end
        nb = 0;
        sh = '0;
        rws_run = 0;
      end
      p_clk = bus_clk;
      p_rws = bus_rws;
      p_dat = bus_dat_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_frame(input string tag, input int idx, input int bits,
                           input logic [7:0] b0, input logic [7:0] b1);
    chk({tag, " frame bits"}, fr_nb[idx], bits);
    if (bits == 16) begin
      chk({tag, " frame byte0"}, fr_w[idx][7:0], b0);
      chk({tag, " frame byte1"}, fr_w[idx][15:8], b1);
    end else begin
      chk({tag, " frame byte"}, fr_w[idx][15:8], b0);
    end
  endtask

  // issue one request and wait for its done pulse; checks R9 along the way
  task automatic do_req(input bit wr, input logic [7:0] addr, input logic [7:0] data,
                        output logic [7:0] rdata);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", busy, 1'b1);
    chk("R9 ready low while busy", req_ready, 1'b0);
    while (!rsp_valid && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) begin
      errors++;
      $display("FAIL R9 done never seen actual=0 expected=1");
    end
    rdata = rsp_rdata;
    @(negedge clk);
    chk("R9 done one cycle", rsp_valid, 1'b0);
    chk("R9 idle after done", {busy, req_ready}, 2'b01);
  endtask

  task automatic t_reset();
    chk("R1 clk idle high", bus_clk, 1'b1);
    chk("R1 rws idle low", bus_rws, 1'b0);
    chk("R1 oe idle low", bus_dat_oe, 1'b0);
    chk("R1 not busy", busy, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
  endtask

  task automatic t_first_write();
    logic [7:0] r;
    int f0 = nfr;
    do_req(1'b1, 8'h03, 8'hA5, r);
    chk("R3 first access switches bank", nfr - f0, 2);
    chk_frame("R3 bank frame", f0, 16, 8'h01, 8'h01);
    chk_frame("R4 write frame", f0 + 1, 16, 8'hA5, 8'h03);
  endtask

  task automatic t_same_bank();
    logic [7:0] r;
    int f0 = nfr;
    do_req(1'b1, 8'h07, 8'h3C, r);
    chk("R3 no switch on same bank", nfr - f0, 1);
    chk_frame("R4 write same bank", f0, 16, 8'h3C, 8'h07);
  endtask

  task automatic t_high_bank();
    logic [7:0] r;
    int f0 = nfr;
    do_req(1'b1, 8'h1F, 8'h96, r);
    chk("R3 switch to upper", nfr - f0, 2);
    chk_frame("R3 upper bank frame", f0, 16, 8'h02, 8'h01);
    chk_frame("R2 offset removed", f0 + 1, 16, 8'h96, 8'h0F);
  endtask

  task automatic t_reads();
    logic [7:0] r;
    int f0 = nfr;
    do_req(1'b0, 8'h1F, 8'h00, r);
    chk("R7 read one frame", nfr - f0, 1);
    chk_frame("R7 address-only frame", f0, 8, 8'h0F, 8'h00);
    chk("R7 read data upper", r, 8'h96);
    f0 = nfr;
    do_req(1'b0, 8'h03, 8'h00, r);
    chk("R3 read switches back", nfr - f0, 2);
    chk_frame("R3 lower bank frame", f0, 16, 8'h01, 8'h01);
    chk_frame("R7 lower address frame", f0 + 1, 8, 8'h03, 8'h00);
    chk("R7 read data lower", r, 8'hA5);
  endtask

  task automatic t_unpowered();
    logic [7:0] r;
    int f0;
    @(negedge clk);
    pwr_en = 1'b0;
    f0 = nfr;
    do_req(1'b1, 8'h15, 8'hFF, r);
    chk("R8 write ignored no frames", nfr - f0, 0);
    do_req(1'b0, 8'h03, 8'h00, r);
    chk("R8 read returns zero", r, 8'h00);
    chk("R8 read no frames", nfr - f0, 0);
    @(negedge clk);
    pwr_en = 1'b1;
    f0 = nfr;
    do_req(1'b0, 8'h15, 8'h00, r);
    chk("R8 ignored write left slave alone", r, 8'h00);
    chk("R8 cache kept lower bank", nfr - f0, 2);
    f0 = nfr;
    do_req(1'b0, 8'h1F, 8'h00, r);
    chk("R8 upper data intact", r, 8'h96);
    chk("R3 cached upper no switch", nfr - f0, 1);
  endtask

  task automatic t_boundary();
    logic [7:0] r;
    int f0 = nfr;
    do_req(1'b1, 8'h0F, 8'h22, r);
    chk("R2 0x0F lower", nfr - f0, 2);
    chk_frame("R2 0x0F bank", f0, 16, 8'h01, 8'h01);
    chk_frame("R2 0x0F address", f0 + 1, 16, 8'h22, 8'h0F);
    f0 = nfr;
    do_req(1'b1, 8'h10, 8'h11, r);
    chk("R2 0x10 upper", nfr - f0, 2);
    chk_frame("R2 0x10 bank", f0, 16, 8'h02, 8'h01);
    chk_frame("R2 0x10 address", f0 + 1, 16, 8'h11, 8'h00);
    do_req(1'b0, 8'h10, 8'h00, r);
    chk("R7 readback 0x10", r, 8'h11);
  endtask

  task automatic t_timing();
    chk("R5 clock lows seen", lw_seen > 0, 1'b1);
    chk("R5 low phase width", lw_bad, 0);
    chk("R5 data stable while high", dat_bad, 0);
    chk("R6 frame setup time", setup_bad, 0);
    chk("R6 idle after frames", {bus_clk, bus_rws, bus_dat_oe}, 3'b100);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_write();
    t_same_bank();
    t_high_bank();
    t_reads();
    t_unpowered();
    t_boundary();
    t_timing();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule